// File: doc/BRIEF.md
# Activity Watchdog with Transition Detector

This block watches a heartbeat line driven by a processor and raises an alarm when the heartbeat goes quiet. Software shows it is alive by toggling the heartbeat. A change in either direction counts as activity. If no change arrives within the programmed timeout, an active-low alarm output falls. That output is meant to drive a non-maskable interrupt request. The next heartbeat change releases the alarm and starts a fresh timeout period.

The heartbeat enters asynchronously. It passes through a synchroniser chain and then a transition detector, which compares the synchronised level with its value one cycle earlier. Any of three conditions holds the timer at zero:
- the system reset is asserted;
- an external flag reports the heartbeat line as undriven (floating);
- a transition has just been detected.

The alarm output is also forced low whenever the supply-good flag is low, whatever the timer holds. With the heartbeat left floating, the output therefore works as a low-line indicator. The timeout is derived from a clock rate and a time in milliseconds. The defaults give 1.6 s at 200 MHz.

Top module: `activity_watchdog`

## Requirements
- R1: With reset released, the undriven flag low and the heartbeat held steady, the timer counts one step on every rising clock edge. The alarm output goes low after the TIMEOUT_CYCLES-th counting edge since the last clear, and not one edge earlier.
- R2: A heartbeat change in either direction clears the timer on the SYNC_STAGES+1-th rising edge after the change. A heartbeat toggled at intervals shorter than the timeout therefore never raises the alarm.
- R3: While rst_n is low, the timer is held at zero and the alarm is inactive, so wdt_n_o equals supply_good_i. Asserting reset in the middle of a count takes effect at once.
- R4: While beat_float_i is high, the timer is held at zero and does not count. An alarm that is already raised is released on the next rising edge, and heartbeat changes have no visible effect.
- R5: Counting restarts from zero on the first rising edge after beat_float_i falls, so the alarm follows TIMEOUT_CYCLES edges later.
- R6: Whenever supply_good_i is low, wdt_n_o is low in the same cycle, whether or not the timer has expired. When the flag returns high, the output shows the timer state again. The timer keeps running through the supply drop.
- R7: Once the alarm is raised, it stays low until a heartbeat change is detected. That change drives wdt_n_o high on the SYNC_STAGES+1-th edge, and the next alarm follows a full TIMEOUT_CYCLES edges later.
- R8: A heartbeat pulse that spans a single rising clock edge registers as activity. Its two transitions clear the timer on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| beat_i | input | 1 | Asynchronous heartbeat from the processor |
| beat_float_i | input | 1 | High when the heartbeat line is sensed as undriven |
| supply_good_i | input | 1 | High while the supply is above its threshold |
| wdt_n_o | output | 1 | Watchdog alarm, active low |

## Verification
The hardest case to reach from the ports is a heartbeat pulse that spans exactly one sampling edge and lands just before expiry. Whether it counts depends on the synchroniser catching a single sample and producing two back-to-back clears. The bench drives the heartbeat a fixed delay after a rising edge and removes it one period later. It places that pulse four cycles before the expected alarm. A cycle-accurate behavioural model then confirms that the alarm moves out by exactly the restart distance. Supply drops are applied both mid-count and while the alarm is already raised, so the override is seen in both states of the timer.

// File: rtl/awd_pkg.sv
package awd_pkg;

   // Width of a counter that must hold the values 0 .. n-1, at least one bit.
   function automatic int awd_cw(input longint unsigned n);
      int w;
      w = $clog2(n);
      if (w < 1) w = 1;
      return w;
   endfunction

   // Timeout length in clock cycles from a clock rate and a time in milliseconds.
   function automatic longint unsigned awd_cycles(input longint unsigned hz,
                                                  input longint unsigned ms);
      return (hz * ms) / 64'd1000;
   endfunction

endpackage

// File: rtl/awd_sync.sv
module awd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("awd_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], d_i};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/awd_edge.sv
module awd_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic edge_o
);

   logic last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= lvl_i;
   end

   // either direction counts as activity
   assign edge_o = lvl_i ^ last_q;

endmodule

// File: rtl/awd_timer.sv
module awd_timer #(
   parameter longint unsigned LIMIT = 64'd320_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic edge_i,
   output logic expired_o
);

   localparam int CW = awd_pkg::awd_cw(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 64'd1);

   logic [CW-1:0] cnt_q;
   logic          exp_q;

   generate
      if (LIMIT < 64'd2) begin : g_bad_limit
         $error("awd_timer: LIMIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (hold_i || edge_i) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else if (!exp_q) begin
         if (cnt_q == LAST) exp_q <= 1'b1;
         else               cnt_q <= cnt_q + CW'(1);
      end
   end

   assign expired_o = exp_q;

   // R1
   expire_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_q) |-> (cnt_q == LAST));

   // R2
   clear_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i |=> (cnt_q == '0 && !exp_q));

   // R4
   float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (cnt_q == '0 && !exp_q));

   // R7
   expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_q && !hold_i && !edge_i) |=> (exp_q && $stable(cnt_q)));

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
   parameter longint unsigned CLK_HZ     = 64'd200_000_000,
   parameter longint unsigned TIMEOUT_MS = 64'd1600,
   parameter int              SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_i,
   input  logic beat_float_i,
   input  logic supply_good_i,
   output logic wdt_n_o
);

   localparam longint unsigned TIMEOUT_CYCLES = awd_pkg::awd_cycles(CLK_HZ, TIMEOUT_MS);

   generate
      if (TIMEOUT_CYCLES < 64'd2) begin : g_bad_timeout
         $error("activity_watchdog: timeout must be at least 2 cycles");
      end
   endgenerate

   logic beat_s;
   logic beat_edge;
   logic timer_expired;

   awd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (beat_i),
      .q_o   (beat_s)
   );

   awd_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (beat_s),
      .edge_o (beat_edge)
   );

   awd_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (beat_float_i),
      .edge_i    (beat_edge),
      .expired_o (timer_expired)
   );

   // supply loss overrides the timer state
   assign wdt_n_o = supply_good_i & ~timer_expired;

endmodule

// File: tb/tb_activity_watchdog.sv
`timescale 1ns/1ps
module tb_activity_watchdog;

   localparam int L  = 20;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic beat = 1'b0;
   logic flt = 1'b0;
   logic sup = 1'b1;
   logic wdt_n;

   int n_tests = 0;
   int n_fail  = 0;
   string cur_req = "R3";

   activity_watchdog #(.CLK_HZ(64'd10_000), .TIMEOUT_MS(64'd2), .SYNC_STAGES(SS)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .beat_i        (beat),
      .beat_float_i  (flt),
      .supply_good_i (sup),
      .wdt_n_o       (wdt_n)
   );

   always #2.5 clk = ~clk;

   // behavioural reference: history of heartbeat samples and a counter
   int m_cnt = 0;
   bit m_exp = 1'b0;
   bit hq[$] = '{0, 0, 0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0;
         m_exp = 1'b0;
         hq = '{0, 0, 0};
      end else begin
         bit seen;
         seen = (hq[SS-1] != hq[SS]);
         if (seen || flt) begin
            m_cnt = 0;
            m_exp = 1'b0;
         end else if (!m_exp) begin
            m_cnt++;
            if (m_cnt == L) m_exp = 1'b1;
         end
         hq.push_front(beat);
         void'(hq.pop_back());
      end
   end

   function automatic bit model_out();
      if (!rst_n) return sup;
      return sup & ~m_exp;
   endfunction

   task automatic chk(input bit act, input bit exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: wdt_n_o=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // compare against the model on every clock, away from the rising edge
   always @(negedge clk) chk(wdt_n, model_out(), cur_req);

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic expect_out(input bit e, input string tag);
      @(negedge clk);
      #0.1;
      chk(wdt_n, e, tag);
   endtask

   initial begin
      // watchdog on the run itself
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R3 reset state
      cur_req = "R3";
      step(4);
      expect_out(1'b1, "R3");
      sup = 1'b0;
      expect_out(1'b0, "R3");
      sup = 1'b1;
      step(1);

      // R1 exact expiry
      cur_req = "R1";
      rst_n = 1'b1;
      step(L - 1);
      expect_out(1'b1, "R1");
      step(1);
      expect_out(1'b0, "R1");
      step(5);
      expect_out(1'b0, "R1");

      // R7 recovery on a rising heartbeat change
      cur_req = "R7";
      beat = 1'b1;
      step(SS);
      expect_out(1'b0, "R7");
      step(1);
      expect_out(1'b1, "R7");
      step(L - 1);
      expect_out(1'b1, "R7");
      step(1);
      expect_out(1'b0, "R7");

      // R2 periodic toggling in both directions keeps the alarm off
      cur_req = "R2";
      for (int i = 0; i < 8; i++) begin
         beat = ~beat;
         step(L / 2);
      end
      expect_out(1'b1, "R2");
      step(L + 4);
      expect_out(1'b0, "R2");

      // R4 floating heartbeat clears and holds
      cur_req = "R4";
      flt = 1'b1;
      step(1);
      expect_out(1'b1, "R4");
      for (int i = 0; i < 6; i++) begin
         beat = ~beat;
         step(L / 2);
      end
      step(3 * L);
      expect_out(1'b1, "R4");

      // R5 counting resumes after the flag drops
      cur_req = "R5";
      flt = 1'b0;
      step(L - 1);
      expect_out(1'b1, "R5");
      step(1);
      expect_out(1'b0, "R5");

      // R6 supply loss while expired, then mid-count
      cur_req = "R6";
      sup = 1'b0;
      expect_out(1'b0, "R6");
      sup = 1'b1;
      expect_out(1'b0, "R6");
      beat = ~beat;
      step(SS + 1 + 5);
      expect_out(1'b1, "R6");
      sup = 1'b0;
      expect_out(1'b0, "R6");
      step(3);
      sup = 1'b1;
      expect_out(1'b1, "R6");
      flt = 1'b1;
      sup = 1'b0;
      expect_out(1'b0, "R6");
      sup = 1'b1;
      flt = 1'b0;
      step(L + 2);
      expect_out(1'b0, "R6");

      // R8 one-edge pulse just before the expected alarm
      cur_req = "R8";
      beat = ~beat;
      step(SS + 1);
      expect_out(1'b1, "R8");
      step(L - 4);
      beat = ~beat;
      step(1);
      beat = ~beat;
      step(6);
      expect_out(1'b1, "R8");
      step(L);
      expect_out(1'b0, "R8");

      // R3 reset mid-count acts at once
      cur_req = "R3";
      beat = ~beat;
      step(SS + 4);
      rst_n = 1'b0;
      expect_out(1'b1, "R3");
      step(2 * L);
      expect_out(1'b1, "R3");
      rst_n = 1'b1;
      step(L + 2);
      expect_out(1'b0, "R3");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule